// File: doc/BRIEF.md
# Writeback Precise Exception Controller

This block is the exception-control slice of a four-register in-order pipeline (fetch-to-decode, decode-to-execute, execute-to-memory, memory-to-writeback). Each pipeline register carries a valid bit, the instruction's PC and a 7-bit exception code. Fetch, decode, execute and memory may each raise a code. A stage keeps any code that is already present and adds its own only when none is present. An instruction that carries a non-zero code changes nothing until it reaches writeback. At that point the controller clears every pipeline register and puts a bubble in place of the instruction being fetched. It then picks the next PC.

The upper three bits of a code give its class and the lower four give its type. Codes of class 1xx send fetch through a vector table. The code is the word address of its vector entry, so the table spans 0x50..0x7F for classes 101 (exceptions), 110 (interrupts) and 111 (traps). The datapath reads that entry on a second memory port and returns it as `vec_word_i`. Class 011 is a return-from-exception, which jumps to the register value the datapath supplies. Code 0x02 halts the machine. The controller also holds the saved return PC, emits a strobe for each kernel-mode history push and pop, and gates data-memory stores.

Top module: `wbx_ctrl`

## Requirements
- R1: After reset the fetch PC is 0, the saved PC is 0, nothing is squashed, the writeback slot is empty, the halted flag is low and no store is enabled.
- R2: When writeback holds a valid instruction with a code whose top bit is set, `vec_addr_o` equals that code and `kpush_o` is high in that cycle. In the next cycle the fetch PC equals the vector word read at that address.
- R3: A code raised at any stage reaches writeback unchanged, and any stage after it does not overwrite it. Fetch and memory raise TLB-miss codes, and decode and execute raise the code presented on their inputs.
- R4: A valid writeback instruction with a non-zero code asserts `squash_o` and clears every younger instruction. None of them reaches writeback, and writeback stays empty for the four cycles that follow.
- R5: The saved PC becomes the faulting instruction's PC for classes 101 and 110, and that PC plus one for class 111 (traps).
- R6: `st_en_o` follows a store request in the memory stage only when that instruction carries code 0, raises no data-access miss, and is not being squashed in that cycle.
- R7: `wb_ifx_o` is 1 when the writeback code was raised at fetch and 0 when it was raised at the data access.
- R8: When an older instruction's code and a younger instruction's fetch miss are in flight together, only the older code is taken. The younger one is discarded and never signals.
- R9: Code 0x02 at writeback squashes the pipeline and sets `halted_o`. From then on the fetch PC no longer advances and no instruction is fetched, until reset.
- R10: A class-011 code at writeback pulses `kpop_o` rather than `kpush_o` and loads the fetch PC from `rfe_target_i`. The saved PC is left unchanged.
- R11: A TLB miss raises code 0x52 when `kmode_i` is 1 and code 0x51 when `kmode_i` is 0. This holds both at fetch and at the data access.
- R12: With no codes raised, the fetch PC advances by one each cycle. The instruction fetched at cycle n is in writeback at cycle n+4 with code 0, and nothing is squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kmode_i | input | 1 | Kernel mode; selects which TLB-miss code is raised |
| fe_miss_i | input | 1 | TLB miss on the fetch at `pc_o` |
| id_code_i | input | 7 | Code raised by decode (trap, privilege, mode op); 0 means none |
| ex_code_i | input | 7 | Code raised by execute; 0 means none |
| mem_store_i | input | 1 | Memory-stage instruction requests a store |
| mem_miss_i | input | 1 | TLB miss on the data access in the memory stage |
| vec_word_i | input | 16 | Vector word read at address `vec_addr_o` |
| rfe_target_i | input | 16 | Return address read from the register of the instruction in writeback |
| pc_o | output | 16 | Fetch PC |
| vec_addr_o | output | 7 | Vector-entry word address (the writeback code) |
| squash_o | output | 1 | Writeback takes a code; all younger work is discarded |
| st_en_o | output | 1 | Data-memory store enable |
| epc_o | output | 16 | Saved return PC |
| kpush_o | output | 1 | Push kernel-mode history and enter kernel mode |
| kpop_o | output | 1 | Pop kernel-mode history |
| halted_o | output | 1 | Machine halted |
| wb_valid_o | output | 1 | Writeback holds an instruction |
| wb_code_o | output | 7 | Writeback code |
| wb_pc_o | output | 16 | Writeback PC |
| wb_ifx_o | output | 1 | Writeback code came from a fetch miss |

## Verification
An instruction fetched while `pc_o` is n is in decode at cycle n+1, in execute at n+2, in memory at n+3 and in writeback at n+4. The bench applies each stage's stimulus in the cycle that matches this schedule. It samples `squash_o`, `vec_addr_o`, `st_en_o` and the mode strobes in the same cycle, after the inputs have settled. The next PC, the saved PC and the halted flag are registered, so they are read one cycle later, at n+5. The pipeline-empty window is read over cycles n+5 to n+8.

// File: rtl/wbx_pkg.sv
// Shared types and code constants for the writeback exception controller.
// Assumes a 16-bit PC and a 7-bit code split as a 3-bit class and a 4-bit type.
package wbx_pkg;
    localparam int PC_W   = 16;
    localparam int CLS_W  = 3;
    localparam int TYP_W  = 4;
    localparam int CODE_W = CLS_W + TYP_W;
    localparam int NSTG   = 4;

    localparam logic [CLS_W-1:0]  CLS_RFE    = 3'b011;
    localparam logic [CLS_W-1:0]  CLS_TRAP   = 3'b111;
    localparam logic [CODE_W-1:0] CODE_HALT  = 7'h02;
    localparam logic [CODE_W-1:0] CODE_UMISS = 7'h51;
    localparam logic [CODE_W-1:0] CODE_KMISS = 7'h52;

    // One pipeline register's control content
    typedef struct packed {
        logic              valid;
        logic              ifx;
        logic [CODE_W-1:0] code;
        logic [PC_W-1:0]   pc;
    } slot_t;

    // TLB-miss code chosen by the current privilege mode
    function automatic logic [CODE_W-1:0] miss_code(input logic km);
        return km ? CODE_KMISS : CODE_UMISS;
    endfunction
endpackage

// File: rtl/wbx_stage.sv
// One pipeline register with code merging.
// It forwards an existing code untouched. It takes raise_code only when the
// incoming instruction is valid and carries code 0. MARK_IFX tags codes that
// originate in this stage as fetch-side. flush clears the register.
module wbx_stage
    import wbx_pkg::*;
#(
    parameter bit MARK_IFX = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  slot_t             d,
    input  logic              raise_en,
    input  logic [CODE_W-1:0] raise_code,
    output slot_t             q
);
    slot_t nxt;

    // merge: oldest code wins, new code only onto a clean instruction
    always_comb begin
        nxt = d;
        if (d.valid && (d.code == '0) && raise_en) begin
            nxt.code = raise_code;
            nxt.ifx  = MARK_IFX;
        end
    end

    // register with synchronous reset and flush
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (flush) q <= '0;
        else            q <= nxt;
    end
endmodule

// File: rtl/wbx_commit.sv
// Writeback decision logic, purely combinational.
// It classifies the writeback code and selects the next fetch PC and the
// saved PC. Assumes the vector word for the writeback code is already valid.
module wbx_commit
    import wbx_pkg::*;
(
    input  slot_t           wb,
    input  logic            halted,
    input  logic [PC_W-1:0] pc_cur,
    input  logic [PC_W-1:0] vec_word,
    input  logic [PC_W-1:0] rfe_target,
    output logic            take,
    output logic            is_vec,
    output logic            is_rfe,
    output logic            is_halt,
    output logic [PC_W-1:0] pc_next,
    output logic [PC_W-1:0] epc_val
);
    logic [CLS_W-1:0] cls;

    // classify the writeback code
    always_comb begin
        cls     = wb.code[CODE_W-1 -: CLS_W];
        take    = wb.valid && (wb.code != '0);
        is_vec  = take && cls[CLS_W-1];
        is_rfe  = take && (cls == CLS_RFE);
        is_halt = take && (wb.code == CODE_HALT);
    end

    // next fetch PC: hold when halted, else redirect on a taken code
    always_comb begin
        if (halted || is_halt) pc_next = pc_cur;
        else if (is_vec)       pc_next = vec_word;
        else if (is_rfe)       pc_next = rfe_target;
        else if (take)         pc_next = wb.pc + 1'b1;
        else                   pc_next = pc_cur + 1'b1;
    end

    // return PC: traps resume past the instruction, others retry it
    always_comb begin
        epc_val = (cls == CLS_TRAP) ? wb.pc + 1'b1 : wb.pc;
    end
endmodule

// File: rtl/wbx_ctrl.sv
// Top of the writeback precise exception controller.
// It owns the fetch PC, the saved return PC and the halted flag, and it
// instantiates the four pipeline control registers and the commit logic.
// Assumes no stalls: every valid instruction moves one stage per cycle.
module wbx_ctrl
    import wbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kmode_i,
    input  logic              fe_miss_i,
    input  logic [CODE_W-1:0] id_code_i,
    input  logic [CODE_W-1:0] ex_code_i,
    input  logic              mem_store_i,
    input  logic              mem_miss_i,
    input  logic [PC_W-1:0]   vec_word_i,
    input  logic [PC_W-1:0]   rfe_target_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [CODE_W-1:0] vec_addr_o,
    output logic              squash_o,
    output logic              st_en_o,
    output logic [PC_W-1:0]   epc_o,
    output logic              kpush_o,
    output logic              kpop_o,
    output logic              halted_o,
    output logic              wb_valid_o,
    output logic [CODE_W-1:0] wb_code_o,
    output logic [PC_W-1:0]   wb_pc_o,
    output logic              wb_ifx_o
);
    localparam int WB  = NSTG - 1;
    localparam int MEM = NSTG - 2;

    logic [PC_W-1:0]   pc_q, epc_q, pc_next, epc_val;
    logic              halted_q, take, is_vec, is_rfe, is_halt;
    slot_t             s_in [NSTG];
    slot_t             s_q  [NSTG];
    logic              raise_en [NSTG];
    logic [CODE_W-1:0] raise_cd [NSTG];

    // per-stage exception sources: fetch miss, decode, execute, data miss
    assign raise_en[0] = fe_miss_i;
    assign raise_cd[0] = miss_code(kmode_i);
    assign raise_en[1] = (id_code_i != '0);
    assign raise_cd[1] = id_code_i;
    assign raise_en[2] = (ex_code_i != '0);
    assign raise_cd[2] = ex_code_i;
    assign raise_en[3] = mem_miss_i;
    assign raise_cd[3] = miss_code(kmode_i);

    // chain of pipeline control registers
    for (genvar i = 0; i < NSTG; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign s_in[i] = '{valid: !halted_q, ifx: 1'b0,
                               code: '0, pc: pc_q};
        end else begin : g_link
            assign s_in[i] = s_q[i-1];
        end
        wbx_stage #(.MARK_IFX(i == 0)) u_stg (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (take),
            .d          (s_in[i]),
            .raise_en   (raise_en[i]),
            .raise_code (raise_cd[i]),
            .q          (s_q[i])
        );
    end

    wbx_commit u_commit (
        .wb         (s_q[WB]),
        .halted     (halted_q),
        .pc_cur     (pc_q),
        .vec_word   (vec_word_i),
        .rfe_target (rfe_target_i),
        .take       (take),
        .is_vec     (is_vec),
        .is_rfe     (is_rfe),
        .is_halt    (is_halt),
        .pc_next    (pc_next),
        .epc_val    (epc_val)
    );

    // fetch PC, saved PC and halted flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            epc_q    <= '0;
            halted_q <= 1'b0;
        end else begin
            pc_q <= pc_next;
            if (is_vec)  epc_q    <= epc_val;
            if (is_halt) halted_q <= 1'b1;
        end
    end

    // store gate: only a clean, unmissed, unsquashed memory-stage instruction
    assign st_en_o = mem_store_i && s_q[MEM].valid && (s_q[MEM].code == '0)
                     && !mem_miss_i && !take;

    assign pc_o       = pc_q;
    assign epc_o      = epc_q;
    assign halted_o   = halted_q;
    assign squash_o   = take;
    assign kpush_o    = is_vec;
    assign kpop_o     = is_rfe;
    assign vec_addr_o = s_q[WB].code;
    assign wb_valid_o = s_q[WB].valid;
    assign wb_code_o  = s_q[WB].code;
    assign wb_pc_o    = s_q[WB].pc;
    assign wb_ifx_o   = s_q[WB].ifx;
endmodule

// File: rtl/wbx_ctrl_chk.sv
// Property checker for wbx_ctrl, attached by bind. Observes ports only.
module wbx_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        squash,
    input logic        wb_valid,
    input logic [6:0]  wb_code,
    input logic [15:0] wb_pc,
    input logic [15:0] vec_word,
    input logic [15:0] pc,
    input logic [15:0] epc,
    input logic        halted,
    input logic        st_en,
    input logic        kpush,
    input logic        kpop
);
    // R4: after a squash, writeback is empty and nothing is squashed again
    p_squash_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (!wb_valid && !squash));

    // R2: a vector-class code redirects fetch to the vector word
    p_vector_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && wb_code[6] && !halted) |=> (pc == $past(vec_word)));

    // R5: traps save the PC after the faulting instruction
    p_trap_epc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && (wb_code[6:4] == 3'b111)) |=> (epc == $past(wb_pc) + 16'd1));

    // R6: no store while the pipeline is being squashed
    p_no_store_on_squash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_en && squash));

    // R9: once halted, stay halted and keep the PC
    p_halt_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc)));

    // R10: a history pop never coincides with a push
    p_push_pop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(kpush && kpop));
endmodule

bind wbx_ctrl wbx_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .squash   (squash_o),
    .wb_valid (wb_valid_o),
    .wb_code  (wb_code_o),
    .wb_pc    (wb_pc_o),
    .vec_word (vec_word_i),
    .pc       (pc_o),
    .epc      (epc_o),
    .halted   (halted_o),
    .st_en    (st_en_o),
    .kpush    (kpush_o),
    .kpop     (kpop_o)
);

// File: tb/sim_wbx_ctrl.sv
`timescale 1ns/1ps
module sim_wbx_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        kmode_i, fe_miss_i, mem_store_i, mem_miss_i;
    logic [6:0]  id_code_i, ex_code_i;
    logic [15:0] vec_word_i, rfe_target_i;
    logic [15:0] pc_o, epc_o, wb_pc_o;
    logic [6:0]  vec_addr_o, wb_code_o;
    logic        squash_o, st_en_o, kpush_o, kpop_o, halted_o, wb_valid_o, wb_ifx_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    // vector table model: entry at word address a holds 0x200 | a
    assign vec_word_i = 16'h0200 | {9'd0, vec_addr_o};

    wbx_ctrl u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clr_in();
        fe_miss_i = 0; id_code_i = 0; ex_code_i = 0;
        mem_store_i = 0; mem_miss_i = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clr_in();
    endtask

    // after this task it is cycle 0: pc_o == 0
    task automatic do_reset();
        rst_n = 0; kmode_i = 0; rfe_target_i = 16'h1234;
        clr_in();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // raise a code at stage s (0 fetch .. 3 memory) for the instruction at PC k
    task automatic run_exc(input int s, input logic [6:0] code, input logic km, input int k);
        logic [6:0] expc;
        expc = (s == 0 || s == 3) ? (km ? 7'h52 : 7'h51) : code;
        do_reset();
        kmode_i = km;
        repeat (k + s) step();
        case (s)
            0: fe_miss_i = 1;
            1: id_code_i = code;
            2: ex_code_i = code;
            default: mem_miss_i = 1;
        endcase
        step();
        repeat (3 - s) step();
        #1;
        check("R4 squash", squash_o, 1);
        check("R3/R11 code", vec_addr_o, expc);
        check("R2 kpush", kpush_o, 1);
        check("R3 wb pc", wb_pc_o, k);
        check("R7 ifx", wb_ifx_o, (s == 0));
        step(); #1;
        check("R2 vector pc", pc_o, 16'h0200 | expc);
        check("R5 epc", epc_o, (expc[6:4] == 3'b111) ? k + 1 : k);
        check("R4 wb empty", wb_valid_o, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(); #1;
        check("R1 pc", pc_o, 0);
        check("R1 epc", epc_o, 0);
        check("R1 squash", squash_o, 0);
        check("R1 wb", wb_valid_o, 0);
        check("R1 halted", halted_o, 0);
        check("R1 store", st_en_o, 0);

        // R12 normal flow
        repeat (8) step(); #1;
        check("R12 pc", pc_o, 8);
        check("R12 wb valid", wb_valid_o, 1);
        check("R12 wb pc", wb_pc_o, 4);
        check("R12 wb code", wb_code_o, 0);
        check("R12 squash", squash_o, 0);

        // R11/R7 misses in both modes, at fetch and at data access
        run_exc(0, 7'h0, 1'b0, 1);
        run_exc(0, 7'h0, 1'b1, 3);
        run_exc(3, 7'h0, 1'b0, 2);
        run_exc(3, 7'h0, 1'b1, 0);

        // R2/R5 sweep of every vector-class code from decode and execute
        for (int c = 8'h50; c < 8'h80; c++) begin
            run_exc(1, c[6:0], 1'b0, 2);
            run_exc(2, c[6:0], 1'b1, 1);
        end

        // R3 forwarding: fetch miss kept over later decode and execute codes
        do_reset();
        repeat (2) step(); fe_miss_i = 1;
        step(); id_code_i = 7'h71;
        step(); ex_code_i = 7'h55;
        step(); step(); #1;
        check("R3 kept code", wb_code_o, 7'h51);
        check("R3 ifx", wb_ifx_o, 1);

        // R8 in-order: older decode trap and younger fetch miss in flight together
        do_reset();
        repeat (3) step();
        id_code_i = 7'h71; fe_miss_i = 1;
        step(); step(); step(); #1;
        check("R8 older code", vec_addr_o, 7'h71);
        step(); #1;
        check("R8 epc", epc_o, 3);
        check("R8 no second squash", squash_o, 0);
        for (int i = 0; i < 3; i++) begin
            step(); #1;
            check("R4 empty window", wb_valid_o, 0);
            check("R8 no younger signal", squash_o, 0);
        end
        step(); #1;
        check("R4 refill", wb_valid_o, 1);
        check("R4 refill pc", wb_pc_o, 16'h0271);

        // R6 store gating
        do_reset();
        repeat (5) step();
        mem_store_i = 1; #1;
        check("R6 clean store", st_en_o, 1);
        mem_miss_i = 1; #1;
        check("R6 data miss store", st_en_o, 0);
        do_reset();
        repeat (3) step(); id_code_i = 7'h53;
        step(); step();
        mem_store_i = 1; #1;
        check("R6 marked store", st_en_o, 0);
        step(); mem_store_i = 1; #1;
        check("R6 squash store", st_en_o, 0);
        check("R4 squash cycle", squash_o, 1);

        // R9 halt
        do_reset();
        repeat (3) step(); id_code_i = 7'h02;
        step(); step(); step(); #1;
        check("R9 squash", squash_o, 1);
        check("R9 no push", kpush_o, 0);
        step(); #1;
        check("R9 halted", halted_o, 1);
        check("R9 pc", pc_o, 6);
        check("R9 epc", epc_o, 0);
        repeat (5) step(); #1;
        check("R9 pc held", pc_o, 6);
        check("R9 still halted", halted_o, 1);
        check("R9 no fetch", wb_valid_o, 0);

        // R10 return from exception
        do_reset();
        repeat (3) step(); id_code_i = 7'h30;
        step(); step(); step(); #1;
        check("R10 pop", kpop_o, 1);
        check("R10 no push", kpush_o, 0);
        step(); #1;
        check("R10 pc", pc_o, 16'h1234);
        check("R10 epc kept", epc_o, 0);
        check("R10 not halted", halted_o, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule